// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block closes the configuration of a programmable device. Once the configuration engine reports that all data has been loaded, the sequencer steps a phase counter through eight phases, 0 to 7, on the configuration clock. On a selectable phase it raises the DONE output. On other selectable phases it releases the hold that keeps all user outputs in high impedance, releases the hold that keeps every flip-flop at its initial value, and turns on the write enable for all RAMs and flip-flops. After phase 7 the loaded design runs freely, and the four outputs keep their final values until the next reset.

Two options change the timing. In the first, called sync-to-DONE here, the output, flip-flop and write releases no longer follow their own phase selections. They wait for the DONE pin, as read back from the pad, to be high. That pin can be held low by other devices on a shared DONE line, so in a daisy chain all devices start together. While they wait, the counter stays on the phase after the DONE phase. In the second, the counter can stop at one chosen phase until a clock-manager lock input goes high. The `stall_o` flag reports a counter that is held for either reason.

Top module: `cfg_startup_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `phase_o` is 0, `done_o` is 0, `hiz_o` is 1, `ffhold_o` is 1, `wr_en_o` is 0 and `stall_o` is 0.
- R2: The sequence starts on the first clock edge at which `cfg_done_i` is high. The step for phase 0 happens on the next edge, and `phase_o` then rises by exactly one per unstalled clock. With DONE selected on phase 1, `done_o` is high three cycles after the cycle in which `cfg_done_i` was first driven high.
- R3: When sync-to-DONE is off, each event takes effect on the clock edge that closes the phase equal to its 3-bit selection. The events are: `done_o` rises, `hiz_o` falls, `ffhold_o` falls, `wr_en_o` rises. Each output then keeps its new value until reset.
- R4: With the selections DONE=1, output release=2, flip-flop release=3 and write enable=3, `hiz_o` falls one clock after `done_o` rises, and `ffhold_o` falls and `wr_en_o` rises together one clock after that.
- R5: With `wait_en_i` high, the counter holds on phase `sel_wait_i` while `lock_i` is low, and no event selected for that phase takes effect. The step for that phase happens on the first edge at which `lock_i` is high.
- R6: With `sync_mode_i` high, the output release, flip-flop release and write enable ignore their selections. All three take effect together on the first unstalled step at which `done_o` is already high and `done_pin_i` is high.
- R7: With `sync_mode_i` high, `done_o` high, `done_pin_i` low and the releases still pending, the counter does not advance. The cycle after each held cycle, `stall_o` is 1.
- R8: After the step for phase 7 the sequence is finished. `phase_o` stays 7, and `cfg_done_i`, `lock_i` and `done_pin_i` have no effect until reset. In sync-to-DONE mode the sequence does not finish until the releases have happened, so phase 7 is repeated until then.
- R9: Once started, the sequence does not depend on `cfg_done_i`; driving it low during the run changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done_i | input | 1 | Configuration data loaded; starts the sequence |
| sel_done_i | input | 3 | Phase of the DONE event |
| sel_hiz_i | input | 3 | Phase of the output high-impedance release |
| sel_ffhold_i | input | 3 | Phase of the flip-flop hold release |
| sel_wren_i | input | 3 | Phase of the write enable |
| sync_mode_i | input | 1 | 1 = releases wait for the DONE pin |
| wait_en_i | input | 1 | 1 = stall at `sel_wait_i` until lock |
| sel_wait_i | input | 3 | Phase at which the lock wait applies |
| lock_i | input | 1 | Clock-manager lock indication |
| done_pin_i | input | 1 | DONE pad level read back, synchronous to `clk` |
| done_o | output | 1 | DONE drive, 1 = high |
| hiz_o | output | 1 | 1 = all user outputs held in high impedance |
| ffhold_o | output | 1 | 1 = all flip-flops held at initial value |
| wr_en_o | output | 1 | 1 = RAM and flip-flop writes enabled |
| phase_o | output | 3 | Current phase |
| stall_o | output | 1 | Counter was held on the previous cycle |

## Verification
The phase counter can be seen on `phase_o` every cycle. A skipped, repeated or early phase shows at the ports one clock after the bad edge, and every later event then lands in the wrong cycle. An event register that fires on the wrong phase, or fails to stay set, shows on its own output in the cycle after the bad edge. A wrong hold decision for lock or sync-to-DONE shows two ways: `phase_o` moves when it should not, and `stall_o` disagrees one cycle later. The bench compares all six outputs with a behavioural model on every clock, so any of these faults is reported within one cycle.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;

  // Event slots, one flop each
  typedef enum logic [1:0] {
    EV_DONE = 2'd0,
    EV_HIZ  = 2'd1,
    EV_FFH  = 2'd2,
    EV_WREN = 2'd3
  } startup_ev_e;

  localparam int NUM_EV = 4;

  // Reset value per event slot (bit index = enum value)
  localparam logic [NUM_EV-1:0] EV_RST_VAL = 4'b0110;

endpackage

// File: rtl/startup_phase_ctr.sv
module startup_phase_ctr #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               step_i,
  input  logic               last_ok_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               run_o,
  output logic               fin_o
);

  localparam logic [PHASE_W-1:0] LAST_PH = '1;

  logic [PHASE_W-1:0] ph_q;
  logic               run_q;
  logic               fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (!run_q && !fin_q) begin
      if (start_i) run_q <= 1'b1;
    end else if (run_q && step_i) begin
      if (ph_q == LAST_PH) begin
        if (last_ok_i) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign phase_o = ph_q;
  assign run_o   = run_q;
  assign fin_o   = fin_q;

endmodule

// File: rtl/startup_hold.sv
module startup_hold #(
  parameter int PHASE_W = 3
) (
  input  logic               run_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               wait_en_i,
  input  logic [PHASE_W-1:0] sel_wait_i,
  input  logic               lock_i,
  input  logic               sync_i,
  input  logic               done_q_i,
  input  logic               pin_i,
  input  logic               rel_q_i,
  output logic               hold_o,
  output logic               step_o,
  output logic               sync_fire_o
);

  logic lock_wait;
  logic pin_wait;

  always_comb begin
    lock_wait   = wait_en_i && (phase_i == sel_wait_i) && !lock_i;
    pin_wait    = sync_i && done_q_i && !pin_i && !rel_q_i;
    hold_o      = run_i && (lock_wait || pin_wait);
    step_o      = run_i && !hold_o;
    sync_fire_o = step_o && sync_i && done_q_i && pin_i;
  end

endmodule

// File: rtl/startup_event_flop.sv
module startup_event_flop #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst)         q_o <= RST_VAL;
    else if (fire_i) q_o <= ~RST_VAL;
  end

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_startup_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_done_i,
  input  logic [PHASE_W-1:0] sel_done_i,
  input  logic [PHASE_W-1:0] sel_hiz_i,
  input  logic [PHASE_W-1:0] sel_ffhold_i,
  input  logic [PHASE_W-1:0] sel_wren_i,
  input  logic               sync_mode_i,
  input  logic               wait_en_i,
  input  logic [PHASE_W-1:0] sel_wait_i,
  input  logic               lock_i,
  input  logic               done_pin_i,
  output logic               done_o,
  output logic               hiz_o,
  output logic               ffhold_o,
  output logic               wr_en_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               stall_o
);

  logic               run_q;
  logic               fin_q;
  logic               hold_w;
  logic               step_w;
  logic               sync_fire_w;
  logic               last_ok_w;
  logic               stall_q;
  logic [NUM_EV-1:0]  ev_q;
  logic [NUM_EV-1:0]  fire_w;
  logic [PHASE_W-1:0] sel_arr [NUM_EV];

  assign sel_arr[EV_DONE] = sel_done_i;
  assign sel_arr[EV_HIZ]  = sel_hiz_i;
  assign sel_arr[EV_FFH]  = sel_ffhold_i;
  assign sel_arr[EV_WREN] = sel_wren_i;

  // Sequence may close only once releases are done in sync mode
  assign last_ok_w = !sync_mode_i || !ev_q[EV_HIZ] || sync_fire_w;

  startup_phase_ctr #(.PHASE_W(PHASE_W)) ctr_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (cfg_done_i),
    .step_i    (step_w),
    .last_ok_i (last_ok_w),
    .phase_o   (phase_o),
    .run_o     (run_q),
    .fin_o     (fin_q)
  );

  startup_hold #(.PHASE_W(PHASE_W)) hold_i (
    .run_i       (run_q),
    .phase_i     (phase_o),
    .wait_en_i   (wait_en_i),
    .sel_wait_i  (sel_wait_i),
    .lock_i      (lock_i),
    .sync_i      (sync_mode_i),
    .done_q_i    (ev_q[EV_DONE]),
    .pin_i       (done_pin_i),
    .rel_q_i     (!ev_q[EV_HIZ]),
    .hold_o      (hold_w),
    .step_o      (step_w),
    .sync_fire_o (sync_fire_w)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    if (g == int'(EV_DONE)) begin : g_plain
      assign fire_w[g] = step_w && (phase_o == sel_arr[g]);
    end else begin : g_rel
      assign fire_w[g] = sync_mode_i ? sync_fire_w
                                     : (step_w && (phase_o == sel_arr[g]));
    end
    startup_event_flop #(.RST_VAL(EV_RST_VAL[g])) flop_i (
      .clk    (clk),
      .rst    (rst),
      .fire_i (fire_w[g]),
      .q_o    (ev_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= hold_w;
  end

  assign done_o   = ev_q[EV_DONE];
  assign hiz_o    = ev_q[EV_HIZ];
  assign ffhold_o = ev_q[EV_FFH];
  assign wr_en_o  = ev_q[EV_WREN];
  assign stall_o  = stall_q;

endmodule

// File: rtl/cfg_startup_chk.sv
module cfg_startup_chk #(
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               run_q,
  input logic               fin_q,
  input logic               wait_en_i,
  input logic [PHASE_W-1:0] sel_wait_i,
  input logic               lock_i,
  input logic               sync_mode_i,
  input logic               done_pin_i,
  input logic               done_o,
  input logic               hiz_o,
  input logic               ffhold_o,
  input logic               wr_en_o,
  input logic [PHASE_W-1:0] phase_o,
  input logic               stall_o
);

  AST_PHASE_INC: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_o) |-> phase_o == PHASE_W'($past(phase_o) + 1'b1)); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o); // R3

  AST_REL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!hiz_o && !ffhold_o && wr_en_o) |=> (!hiz_o && !ffhold_o && wr_en_o)); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_q && wait_en_i && phase_o == sel_wait_i && !lock_i)
      |=> $stable(phase_o) && stall_o); // R5

  AST_SYNC_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (sync_mode_i && $fell(hiz_o)) |-> (!ffhold_o && wr_en_o)); // R6

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_q && sync_mode_i && done_o && !done_pin_i && hiz_o)
      |=> $stable(phase_o) && hiz_o); // R7

  AST_STALL_HELD: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> $stable(phase_o)); // R7

  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> fin_q && $stable({done_o, hiz_o, ffhold_o, wr_en_o, phase_o})); // R8

endmodule

bind cfg_startup_seq cfg_startup_chk #(.PHASE_W(PHASE_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .run_q       (run_q),
  .fin_q       (fin_q),
  .wait_en_i   (wait_en_i),
  .sel_wait_i  (sel_wait_i),
  .lock_i      (lock_i),
  .sync_mode_i (sync_mode_i),
  .done_pin_i  (done_pin_i),
  .done_o      (done_o),
  .hiz_o       (hiz_o),
  .ffhold_o    (ffhold_o),
  .wr_en_o     (wr_en_o),
  .phase_o     (phase_o),
  .stall_o     (stall_o)
);

// File: tb/cfg_startup_seq_tb.sv
`timescale 1ns/1ps
module cfg_startup_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg = 1'b0;
  logic [2:0] s_done = 3'd1, s_hiz = 3'd2, s_ffh = 3'd3, s_wren = 3'd3, s_wait = 3'd0;
  logic       sync = 1'b0, wait_en = 1'b0, lock = 1'b0, pin = 1'b0;
  logic       done_o, hiz_o, ffhold_o, wr_en_o, stall_o;
  logic [2:0] phase_o;

  int    n_chk = 0, n_err = 0;
  bit    cmp_on = 1'b0, ended = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  int m_ph, m_run, m_fin, m_done, m_hiz, m_ffh, m_wren, m_stall;

  always #2.5 clk = ~clk;

  cfg_startup_seq dut_i (
    .clk(clk), .rst(rst), .cfg_done_i(cfg),
    .sel_done_i(s_done), .sel_hiz_i(s_hiz), .sel_ffhold_i(s_ffh), .sel_wren_i(s_wren),
    .sync_mode_i(sync), .wait_en_i(wait_en), .sel_wait_i(s_wait), .lock_i(lock),
    .done_pin_i(pin), .done_o(done_o), .hiz_o(hiz_o), .ffhold_o(ffhold_o),
    .wr_en_o(wr_en_o), .phase_o(phase_o), .stall_o(stall_o)
  );

  always @(posedge clk) begin
    int  old_done, old_hiz, h;
    if (rst) begin
      m_ph = 0; m_run = 0; m_fin = 0; m_done = 0;
      m_hiz = 1; m_ffh = 1; m_wren = 0; m_stall = 0;
    end else begin
      old_done = m_done; old_hiz = m_hiz;
      h = m_run && ((wait_en && m_ph == s_wait && !lock) ||
                    (sync && old_done && !pin && old_hiz));
      if (!m_run && !m_fin) begin
        if (cfg) m_run = 1;
      end else if (m_run && !h) begin
        if (m_ph == s_done) m_done = 1;
        if (sync) begin
          if (old_done && pin) begin m_hiz = 0; m_ffh = 0; m_wren = 1; end
        end else begin
          if (m_ph == s_hiz)  m_hiz  = 0;
          if (m_ph == s_ffh)  m_ffh  = 0;
          if (m_ph == s_wren) m_wren = 1;
        end
        if (m_ph == 7) begin
          if (!sync || m_hiz == 0) begin m_run = 0; m_fin = 1; end
        end else m_ph++;
      end
      m_stall = h;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !ended) begin
      n_chk++;
      if (phase_o != m_ph[2:0] || done_o != m_done[0] || hiz_o != m_hiz[0] ||
          ffhold_o != m_ffh[0] || wr_en_o != m_wren[0] || stall_o != m_stall[0]) begin
        n_err++;
        $display("FAIL %s model: act ph=%0d d=%0b z=%0b f=%0b w=%0b s=%0b exp ph=%0d d=%0d z=%0d f=%0d w=%0d s=%0d",
                 cur_req, phase_o, done_o, hiz_o, ffhold_o, wr_en_o, stall_o,
                 m_ph, m_done, m_hiz, m_ffh, m_wren, m_stall);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cfg = 1'b0;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int t_done, t_hiz, t_ffh;
    tick(1);
    cmp_on = 1'b1;
    // ---- R1 reset state
    tick(3);
    chk("R1 phase", phase_o, 0); chk("R1 done", done_o, 0); chk("R1 hiz", hiz_o, 1);
    rst = 1'b0;
    tick(1);
    chk("R1 ffhold", ffhold_o, 1); chk("R1 wren", wr_en_o, 0); chk("R1 stall", stall_o, 0);

    // ---- R2 idle until start, default timing R4, R9 drop cfg
    cur_req = "R2";
    tick(4);
    chk("R2 idle phase", phase_o, 0); chk("R2 idle done", done_o, 0);
    cfg = 1'b1;
    t_done = -1; t_hiz = -1; t_ffh = -1;
    for (int c = 1; c <= 14; c++) begin
      @(negedge clk);
      if (c == 1) cfg = 1'b0; // R9: dropped after start
      if (t_done < 0 && done_o)    t_done = c;
      if (t_hiz < 0 && !hiz_o)     t_hiz = c;
      if (t_ffh < 0 && !ffhold_o)  t_ffh = c;
    end
    cur_req = "R4";
    chk("R2 done cycle", t_done, 3);
    chk("R4 hiz after done", t_hiz - t_done, 1);
    chk("R4 ffhold after hiz", t_ffh - t_hiz, 1);
    chk("R4 wren final", wr_en_o, 1);
    chk("R9 finished despite cfg low", phase_o, 7);
    cur_req = "R8";
    cfg = 1'b1; lock = 1'b1; pin = 1'b1;
    tick(4);
    chk("R8 phase held", phase_o, 7); chk("R8 done kept", done_o, 1);
    chk("R8 hiz kept", hiz_o, 0);
    cfg = 1'b0; lock = 1'b0; pin = 1'b0;

    // ---- R3 custom selections
    cur_req = "R3";
    s_done = 3'd5; s_hiz = 3'd0; s_ffh = 3'd7; s_wren = 3'd4;
    do_reset();
    cfg = 1'b1;
    tick(2);
    cfg = 1'b0;
    chk("R3 hiz on phase 0", hiz_o, 0); chk("R3 done not yet", done_o, 0);
    tick(12);
    chk("R3 done final", done_o, 1); chk("R3 ffhold final", ffhold_o, 1 - 1);
    chk("R3 wren final", wr_en_o, 1);

    // ---- R5 lock wait
    cur_req = "R5";
    s_done = 3'd1; s_hiz = 3'd2; s_ffh = 3'd3; s_wren = 3'd3;
    wait_en = 1'b1; s_wait = 3'd3; lock = 1'b0;
    do_reset();
    cfg = 1'b1;
    tick(15);
    chk("R5 phase held", phase_o, 3); chk("R5 stall", stall_o, 1);
    chk("R5 ffhold waits", ffhold_o, 1); chk("R5 done passed", done_o, 1);
    lock = 1'b1;
    tick(1);
    chk("R5 ffhold after lock", ffhold_o, 0); chk("R5 phase moved", phase_o, 4);
    tick(8);
    wait_en = 1'b0; lock = 1'b0;

    // ---- R6/R7 sync to DONE pin
    cur_req = "R7";
    sync = 1'b1; s_done = 3'd2; s_hiz = 3'd0; s_ffh = 3'd1; s_wren = 3'd1; pin = 1'b0;
    do_reset();
    cfg = 1'b1;
    tick(12);
    chk("R7 phase held after DONE", phase_o, 3); chk("R7 stall", stall_o, 1);
    chk("R6 hiz selection ignored", hiz_o, 1); chk("R6 ffhold selection ignored", ffhold_o, 1);
    chk("R7 done high", done_o, 1);
    cur_req = "R6";
    pin = 1'b1;
    tick(1);
    chk("R6 hiz released", hiz_o, 0); chk("R6 ffhold released", ffhold_o, 0);
    chk("R6 wren on", wr_en_o, 1); chk("R6 phase moved", phase_o, 4);
    tick(6);
    chk("R8 sync finished", phase_o, 7);

    // ---- R8 sync with DONE on phase 7
    cur_req = "R8";
    s_done = 3'd7; pin = 1'b0;
    do_reset();
    cfg = 1'b1;
    tick(14);
    chk("R8 phase 7 repeated", phase_o, 7); chk("R8 hiz pending", hiz_o, 1);
    chk("R8 stall at 7", stall_o, 1);
    pin = 1'b1;
    tick(2);
    chk("R8 hiz released at 7", hiz_o, 0); chk("R8 wren at 7", wr_en_o, 1);
    tick(3);
    finish_run();
  end

endmodule